// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block sits between a synchronous host and a bank of asynchronous byte-wide EPROMs that share one address bus, one data bus and one output-enable strobe. Each device has its own active-low chip-enable. The host presents a request together with a wide address. The upper bits of that address pick the device and the lower 19 bits address a byte inside it. The controller then drives the device pins through a fixed timing sequence and returns the sampled byte with a one-cycle valid pulse.

All device timing is given in nanoseconds: address access, chip-enable access, output-enable access and output float time. Each value becomes a cycle count by rounding up its division by the clock-period parameter. Output-enable is held back until address and chip-enable have been stable long enough that the output-enable access time alone sets the remaining wait. After a read ends, a turnaround counter stops the shared output-enable from going low again until the previous device has had its float time to release the bus. The address pins change only when a new read is accepted, so the zero output hold time is never violated.

Top module: `eprom_read_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `ready_o` is 1, every `mem_ce_n_o` line is 1, `mem_oe_n_o` is 1 and `rvalid_o` is 0.
- R2: A request is taken at the clock edge where `req_i` and `ready_o` are both 1. At that edge `mem_addr_o` takes `addr_i[ADDR_W-1:0]`, the chip-enable line whose index equals `addr_i[ADDR_W+SEL_W-1:ADDR_W]` goes to 0, and `ready_o` goes to 0. `ready_o` stays 0 until the read ends.
- R3: No more than one chip-enable line is ever 0. Every line not selected by the current read stays 1.
- R4: Let AC = max(ceil(T_AA_NS/CLK_PERIOD_NS), ceil(T_CE_NS/CLK_PERIOD_NS)), OE = ceil(T_OE_NS/CLK_PERIOD_NS) and LEAD = max(AC - OE, 0). If the bus is already free, `mem_oe_n_o` goes to 0 at edge k + LEAD + 1, where k is the accept edge.
- R5: If output-enable went low at edge e, then at edge e + OE + 1 the controller captures `mem_dq_i` into `rdata_o`, raises `rvalid_o` for exactly one cycle, returns all chip-enables and `mem_oe_n_o` to 1 and sets `ready_o` to 1.
- R6: `mem_addr_o` does not change from the accept edge until the capture edge.
- R7: Let DF = ceil(T_DF_NS/CLK_PERIOD_NS). If the previous read ended at edge s, `mem_oe_n_o` does not go to 0 before edge s + DF + 1. The low edge for the new read is the later of that edge and the one given in R4.
- R8: Changes on `req_i` and `addr_i` while `ready_o` is 0 have no effect. The read in progress returns the byte for the address accepted, and `rdata_o` keeps its value between capture edges.
- R9: The single `mem_oe_n_o` output is 0 only while some chip-enable line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Host read request |
| addr_i | input | ADDR_W+SEL_W | Host byte address; upper SEL_W bits select the device |
| ready_o | output | 1 | Controller idle and able to accept a request |
| rdata_o | output | DATA_W | Last byte read |
| rvalid_o | output | 1 | One-cycle pulse when `rdata_o` holds a new byte |
| mem_addr_o | output | ADDR_W | Address bus to the device bank |
| mem_ce_n_o | output | NUM_DEV | Per-device chip-enable, active low |
| mem_oe_n_o | output | 1 | Shared output-enable, active low |
| mem_dq_i | input | DATA_W | Data bus from the device bank |

## Verification
An isolated read after a long idle gap shows the access-time limit, because output-enable timing then follows R4 alone. Back-to-back reads to different devices with the request held high show the float-time limit: the new output-enable edge must move later, to s + DF + 1, and this tells a design that honours turnaround apart from one that only counts access time. During those busy periods the host address is flipped to its complement, so a design that re-reads `addr_i` after acceptance returns the wrong byte. The bench device model puts out a garbage byte until the nanosecond access times have elapsed, so any early sampling shows up in the returned data.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LEAD   = 2'd1,
    ST_ACCESS = 2'd2
  } rd_state_e;

  // Round a nanosecond figure up to whole clock cycles.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eprom_countdown.sv
module eprom_countdown #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/eprom_ce_decode.sv
module eprom_ce_decode #(
  parameter int NUM_DEV = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [NUM_DEV-1:0] ce_n_o
);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_line
    logic ce_n_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        ce_n_q <= 1'b1;
      end else if (clr_i) begin
        ce_n_q <= 1'b1;
      end else if (set_i) begin
        ce_n_q <= (sel_i != SEL_W'(g));
      end
    end
    assign ce_n_o[g] = ce_n_q;
  end

endmodule

// File: rtl/eprom_read_ctrl.sv
module eprom_read_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int NUM_DEV       = 4,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_AA_NS       = 70,
  parameter int T_CE_NS       = 70,
  parameter int T_OE_NS       = 40,
  parameter int T_DF_NS       = 50
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 req_i,
  input  logic [ADDR_W+$clog2(NUM_DEV)-1:0]    addr_i,
  output logic                                 ready_o,
  output logic [DATA_W-1:0]                    rdata_o,
  output logic                                 rvalid_o,
  output logic [ADDR_W-1:0]                    mem_addr_o,
  output logic [NUM_DEV-1:0]                   mem_ce_n_o,
  output logic                                 mem_oe_n_o,
  input  logic [DATA_W-1:0]                    mem_dq_i
);

  localparam int SEL_W   = $clog2(NUM_DEV);
  localparam int AA_CYC  = ns_to_cyc(T_AA_NS, CLK_PERIOD_NS);
  localparam int CE_CYC  = ns_to_cyc(T_CE_NS, CLK_PERIOD_NS);
  localparam int OE_CYC  = ns_to_cyc(T_OE_NS, CLK_PERIOD_NS);
  localparam int DF_CYC  = ns_to_cyc(T_DF_NS, CLK_PERIOD_NS);
  localparam int AC_CYC  = imax(AA_CYC, CE_CYC);
  localparam int LEAD    = (AC_CYC > OE_CYC) ? (AC_CYC - OE_CYC) : 0;
  localparam int CNT_W   = $clog2(imax(imax(LEAD, OE_CYC), DF_CYC) + 1);

  rd_state_e state_q;
  logic      lead_zero, acc_zero, float_zero;
  logic      accept, oe_go, done;

  assign accept = (state_q == ST_IDLE) && req_i;
  assign oe_go  = (state_q == ST_LEAD) && lead_zero && float_zero;
  assign done   = (state_q == ST_ACCESS) && acc_zero;

  // Wait from accept until output-enable may fall.
  eprom_countdown #(.W(CNT_W)) u_lead_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .val_i  (CNT_W'(LEAD)),
    .zero_o (lead_zero)
  );

  // Wait from output-enable low until the capture edge.
  eprom_countdown #(.W(CNT_W)) u_acc_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (oe_go),
    .val_i  (CNT_W'(OE_CYC)),
    .zero_o (acc_zero)
  );

  // Bus turnaround: previous device may still drive for the float time.
  eprom_countdown #(.W(CNT_W)) u_float_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (done),
    .val_i  (CNT_W'(DF_CYC)),
    .zero_o (float_zero)
  );

  eprom_ce_decode #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_ce_dec (
    .clk    (clk),
    .rst    (rst),
    .set_i  (accept),
    .clr_i  (done),
    .sel_i  (addr_i[ADDR_W+SEL_W-1:ADDR_W]),
    .ce_n_o (mem_ce_n_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ready_o    <= 1'b1;
      mem_oe_n_o <= 1'b1;
      rvalid_o   <= 1'b0;
      rdata_o    <= '0;
      mem_addr_o <= '0;
    end else begin
      rvalid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            mem_addr_o <= addr_i[ADDR_W-1:0];
            ready_o    <= 1'b0;
            state_q    <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (oe_go) begin
            mem_oe_n_o <= 1'b0;
            state_q    <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (done) begin
            rdata_o    <= mem_dq_i;
            rvalid_o   <= 1'b1;
            mem_oe_n_o <= 1'b1;
            ready_o    <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  one_ce_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_ce_n_o));

  // R9
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n_o |-> !(&mem_ce_n_o));

  // R7
  oe_float_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n_o) |-> $past(float_zero));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready_o && $past(!ready_o)) |-> $stable(mem_addr_o));

  // R5
  valid_after_oe_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |-> ($past(!mem_oe_n_o) && mem_oe_n_o && ready_o));

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n_o |-> !ready_o);

endmodule

// File: tb/eprom_read_ctrl_tb.sv
`timescale 1ns/1ps
module eprom_read_ctrl_tb;

  localparam int ADDR_W = 19;
  localparam int DATA_W = 8;
  localparam int NDEV   = 4;
  localparam int SELW   = 2;
  localparam int PER    = 4;
  localparam int TAA = 70, TCE = 70, TOE = 40, TDF = 50;

  // Cycle figures from the requirements, computed here.
  localparam int C_AA  = (TAA + PER - 1) / PER;
  localparam int C_CE  = (TCE + PER - 1) / PER;
  localparam int C_OE  = (TOE + PER - 1) / PER;
  localparam int C_DF  = (TDF + PER - 1) / PER;
  localparam int C_AC  = (C_AA > C_CE) ? C_AA : C_CE;
  localparam int C_LD  = (C_AC > C_OE) ? C_AC - C_OE : 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_i = 1'b0;
  logic [ADDR_W+SELW-1:0] addr_i = '0;
  logic ready_o, rvalid_o, mem_oe_n_o;
  logic [DATA_W-1:0] rdata_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [NDEV-1:0]   mem_ce_n_o;
  logic [DATA_W-1:0] mem_dq_i = 8'hA5;

  always #(PER/2.0) clk = ~clk;

  eprom_read_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DEV(NDEV), .CLK_PERIOD_NS(PER),
    .T_AA_NS(TAA), .T_CE_NS(TCE), .T_OE_NS(TOE), .T_DF_NS(TDF)
  ) u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .ready_o(ready_o),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .mem_addr_o(mem_addr_o),
    .mem_ce_n_o(mem_ce_n_o), .mem_oe_n_o(mem_oe_n_o), .mem_dq_i(mem_dq_i)
  );

  int n_checks = 0;
  int n_fail   = 0;

  function automatic logic [7:0] pat(input int dev, input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[18:11] ^ 8'(dev * 59 + 17);
  endfunction

  // Device bank model: valid byte only after the nanosecond access times.
  realtime t_ac = 0.0, t_oe = 0.0;
  always @(mem_addr_o or mem_ce_n_o) t_ac = $realtime;
  always @(negedge mem_oe_n_o) t_oe = $realtime;

  initial begin
    #(PER/8.0);
    forever begin
      #(PER/4.0);
      begin
        int dev;
        dev = -1;
        for (int i = 0; i < NDEV; i++) if (!mem_ce_n_o[i]) dev = i;
        if (dev >= 0 && !mem_oe_n_o && ($realtime - t_ac >= TAA) &&
            ($realtime - t_oe >= TOE))
          mem_dq_i = pat(dev, mem_addr_o);
        else
          mem_dq_i = 8'hA5;
      end
    end
  end

  // Cycle-by-cycle reference model keyed on edge numbers.
  int  n_edge = 0;
  int  m_st = 0;
  int  m_k = 0, m_e = 0, m_s = -1000;
  int  m_dev = 0;
  logic                 m_ready = 1'b1, m_oe = 1'b1, m_valid = 1'b0;
  logic [NDEV-1:0]      m_ce = '1;
  logic [ADDR_W-1:0]    m_addr = '0;
  logic [DATA_W-1:0]    m_rdata = '0;

  always @(posedge clk) begin
    if (rst) begin
      n_edge = 0; m_st = 0; m_s = -1000;
      m_ready = 1'b1; m_oe = 1'b1; m_valid = 1'b0; m_ce = '1;
      m_addr = '0; m_rdata = '0;
    end else begin
      n_edge++;
      m_valid = 1'b0;
      case (m_st)
        0: if (req_i) begin
             m_addr  = addr_i[ADDR_W-1:0];
             m_dev   = int'(addr_i[ADDR_W+SELW-1:ADDR_W]);
             m_ce    = '1;
             m_ce[m_dev] = 1'b0;
             m_ready = 1'b0;
             m_k     = n_edge;
             m_st    = 1;
           end
        1: if (n_edge >= m_k + C_LD + 1 && n_edge >= m_s + C_DF + 1) begin
             m_oe = 1'b0; m_e = n_edge; m_st = 2;
           end
        default: if (n_edge == m_e + C_OE + 1) begin
             m_rdata = pat(m_dev, m_addr);
             m_valid = 1'b1; m_oe = 1'b1; m_ce = '1; m_ready = 1'b1;
             m_s = n_edge; m_st = 0;
           end
      endcase
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2", "ready_o", 32'(ready_o), 32'(m_ready));
      chk("R3", "mem_ce_n_o", 32'(mem_ce_n_o), 32'(m_ce));
      chk("R4/R7/R9", "mem_oe_n_o", 32'(mem_oe_n_o), 32'(m_oe));
      chk("R5", "rvalid_o", 32'(rvalid_o), 32'(m_valid));
      chk("R8", "rdata_o", 32'(rdata_o), 32'(m_rdata));
      chk("R6", "mem_addr_o", 32'(mem_addr_o), 32'(m_addr));
    end
  end

  task automatic read_one(input int dev, input logic [ADDR_W-1:0] a, input bit keep);
    logic [ADDR_W+SELW-1:0] full;
    full = {SELW'(dev), a};
    req_i  = 1'b1;
    addr_i = full;
    @(negedge clk);
    while (m_st == 0) @(negedge clk);
    if (keep) addr_i = ~full;   // R8: noise while busy
    else      req_i  = 1'b0;
    while (!rvalid_o) @(negedge clk);
    chk("R5", "returned byte", 32'(rdata_o), 32'(pat(dev, a)));
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1", "ready_o after reset", 32'(ready_o), 32'd1);
    chk("R1", "ce after reset", 32'(mem_ce_n_o), 32'hF);
    chk("R1", "oe after reset", 32'(mem_oe_n_o), 32'd1);
    chk("R1", "rvalid after reset", 32'(rvalid_o), 32'd0);

    // Isolated read: lead-limited output-enable (R4).
    read_one(0, 19'h12345, 1'b0);
    repeat (20) @(negedge clk);
    read_one(2, 19'h7FFFF, 1'b0);
    @(negedge clk);
    // Back-to-back with request held: float-limited (R7), busy noise (R8).
    read_one(1, 19'h00000, 1'b1);
    read_one(3, 19'h2AAAA, 1'b1);
    read_one(2, 19'h55555, 1'b1);
    read_one(1, 19'h4C1F0, 1'b0);
    // R8: rdata holds while idle and addr_i moves.
    addr_i = '1;
    repeat (10) @(negedge clk);
    chk("R8", "rdata held while idle", 32'(rdata_o), 32'(pat(1, 19'h4C1F0)));
    chk("R3", "all ce high when idle", 32'(mem_ce_n_o), 32'hF);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(PER * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule